// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits next to a small 16-bit segmented processor core and carries out interrupt entry and interrupt return on the core's behalf. At each instruction boundary the core signals, the block looks at the pending sources and picks one. The sources are a trap raised by the core itself (a software trap instruction or a divide overflow, with the type number supplied by the core), an edge-triggered non-maskable request, a level-sensitive maskable request and the single-step trap. For a maskable request it first runs an acknowledge cycle that reads an 8-bit type number from the bus.

It then pushes the flags, code segment and instruction pointer onto the stack through a word-wide request/acknowledge memory port. It reads the new instruction pointer and code segment from the vector table in segment zero, and presents the new core state with a one-cycle load strobe. A return request at a boundary instead pops the instruction pointer, code segment and flags, and hands them back in the same way.

Physical addresses are the segment shifted left by four plus the offset, truncated to the address width. The flags word keeps interrupt-enable in bit 9 and trap in bit 8.

Top module: `int_entry_seq`

## Requirements
- R1: For vector type n, the instruction pointer is read from byte address n*4 and the code segment from n*4+2, both in segment zero, and these read values appear on `ip_o` and `cs_o` at the load strobe.
- R2: Entry writes the flags word to SS:SP-2, then the code segment to SS:SP-4, then the instruction pointer to SS:SP-6, and `sp_o` is SP-6 at the load strobe.
- R3: On entry, `flags_o` equals the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared. The word pushed on the stack is the unmodified flags word.
- R4: When several sources are pending at one boundary, the order of service is core trap first, then non-maskable, then maskable, then single step.
- R5: A rising edge on `nmi_i` is held pending until it is served, and it is always served as type 2. Holding `nmi_i` high does not raise a second request.
- R6: A maskable request is taken only when flags bit 9 is 1 at the boundary. When it is taken, `inta_o` is high for exactly one cycle, no memory request is active in that cycle, and the type is taken from `ext_type_i` in that cycle. A maskable request with bit 9 at 0 and nothing else pending starts no activity.
- R7: With flags bit 8 set and no other source pending, a boundary starts a type 1 entry.
- R8: A return request at a boundary takes precedence over all interrupt sources. It reads the instruction pointer from SS:SP, the code segment from SS:SP+2 and the flags from SS:SP+4, then presents them unchanged with `sp_o` equal to SP+6.
- R9: `busy_o` rises the cycle after the boundary is taken and stays high up to and including the single cycle of `load_o`. It falls in the cycle after `load_o`.
- R10: Each memory request holds its address, write enable and write data stable until `mem_ack_i`. The sequencer moves to the next access in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary pulse from the core |
| iret_req_i | input | 1 | Return-from-interrupt request at this boundary |
| trap_req_i | input | 1 | Core-raised trap (software trap or divide overflow) |
| trap_type_i | input | 8 | Type number of the core trap |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable request, level sensitive |
| ext_type_i | input | 8 | Type number driven on the bus during acknowledge |
| inta_o | output | 1 | Acknowledge strobe for the maskable request |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer (return address) |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Current stack pointer |
| flags_i | input | 16 | Current flags word |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Sequence in progress |
| load_o | output | 1 | One-cycle strobe: new core state valid |
| cs_o | output | 16 | New code segment |
| ip_o | output | 16 | New instruction pointer |
| sp_o | output | 16 | New stack pointer |
| flags_o | output | 16 | New flags word |

## Verification
The bench's memory model acknowledges one cycle after a request is raised, so every word access takes two cycles. Counting from the clock edge that takes the boundary, the load strobe is due 10 cycles later for a trap, non-maskable or step entry, 11 cycles later for a maskable entry (one extra acknowledge cycle), and 6 cycles later for a return. The bench records the cycle count at the boundary edge and samples every output on falling edges. It requires the first falling edge with `load_o` high to fall exactly at the expected count, and only then compares the new state and the stack words written by the pushes.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK, ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP,
    ST_RD_IP, ST_RD_CS, ST_POP_IP, ST_POP_CS, ST_POP_F, ST_LOAD
  } seq_state_e;

  // grant index order is the service priority
  localparam int SRC_TRAP = 0;
  localparam int SRC_NMI  = 1;
  localparam int SRC_INTR = 2;
  localparam int SRC_STEP = 3;
  localparam int NSRC     = 4;

  localparam int FLAG_IF = 9;
  localparam int FLAG_TF = 8;

  localparam logic [7:0] NMI_TYPE  = 8'd2;
  localparam logic [7:0] STEP_TYPE = 8'd1;
endpackage

// File: rtl/int_nmi_edge.sv
module int_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_o <= (pend_o & ~clr_i) | (nmi_i & ~nmi_q);
    end
  end

  // R5
  nmi_edge_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_i) |=> pend_o);
  // R5
  nmi_pend_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !clr_i |=> pend_o);
endmodule

// File: rtl/int_src_arb.sv
module int_src_arb
  import int_seq_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          trap_i,
  input  logic [TW-1:0] trap_type_i,
  input  logic          nmi_pend_i,
  input  logic          intr_i,
  input  logic          if_i,
  input  logic          tf_i,
  output logic          any_o,
  output logic [NSRC-1:0] grant_o,
  output logic [TW-1:0] type_o
);
  logic [NSRC-1:0] req;

  assign req[SRC_TRAP] = trap_i;
  assign req[SRC_NMI]  = nmi_pend_i;
  assign req[SRC_INTR] = intr_i & if_i;
  assign req[SRC_STEP] = tf_i;

  always_comb begin
    grant_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) grant_o = NSRC'(1) << i;
    end
  end

  assign any_o = |req;

  always_comb begin
    type_o = '0;
    if (grant_o[SRC_TRAP])      type_o = trap_type_i;
    else if (grant_o[SRC_NMI])  type_o = TW'(NMI_TYPE);
    else if (grant_o[SRC_STEP]) type_o = TW'(STEP_TYPE);
  end
endmodule

// File: rtl/int_addr_gen.sv
module int_addr_gen
  import int_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  seq_state_e    state_i,
  input  logic [DW-1:0] ss_i,
  input  logic [DW-1:0] sp_i,
  input  logic [TW-1:0] vtype_i,
  output logic [AW-1:0] addr_o
);
  localparam int SH = AW - DW;

  logic [AW-1:0] stk_base;
  logic [AW-1:0] vec_base;
  logic [DW-1:0] push_off;

  assign stk_base = AW'({ss_i, {SH{1'b0}}});
  assign vec_base = AW'({vtype_i, 2'b00});
  assign push_off = sp_i - DW'(2);

  always_comb begin
    unique case (state_i)
      ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: addr_o = stk_base + AW'(push_off);
      ST_POP_IP, ST_POP_CS, ST_POP_F:    addr_o = stk_base + AW'(sp_i);
      ST_RD_IP:                          addr_o = vec_base;
      ST_RD_CS:                          addr_o = vec_base + AW'(2);
      default:                           addr_o = '0;
    endcase
  end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import int_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boundary_i,
  input  logic          iret_req_i,
  input  logic          trap_req_i,
  input  logic [TW-1:0] trap_type_i,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic [TW-1:0] ext_type_i,
  output logic          inta_o,
  input  logic [DW-1:0] cs_i,
  input  logic [DW-1:0] ip_i,
  input  logic [DW-1:0] ss_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] flags_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          load_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] ip_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] flags_o
);
  localparam logic [DW-1:0] CLR_MASK = ~((DW'(1) << FLAG_IF) | (DW'(1) << FLAG_TF));

  seq_state_e      state;
  logic [DW-1:0]   sp_w, cs_s, ip_s, flags_s, new_cs, new_ip;
  logic [TW-1:0]   vtype;
  logic            entry_q;
  logic            nmi_pend, nmi_clr, arb_any, take_int, take_ret;
  logic [NSRC-1:0] grant;
  logic [TW-1:0]   arb_type;

  int_nmi_edge u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  int_src_arb #(.TW(TW)) u_arb (
    .trap_i      (trap_req_i),
    .trap_type_i (trap_type_i),
    .nmi_pend_i  (nmi_pend),
    .intr_i      (intr_i),
    .if_i        (flags_i[FLAG_IF]),
    .tf_i        (flags_i[FLAG_TF]),
    .any_o       (arb_any),
    .grant_o     (grant),
    .type_o      (arb_type)
  );

  int_addr_gen #(.AW(AW), .DW(DW), .TW(TW)) u_addr (
    .state_i (state),
    .ss_i    (ss_i),
    .sp_i    (sp_w),
    .vtype_i (vtype),
    .addr_o  (mem_addr_o)
  );

  assign take_ret = (state == ST_IDLE) && boundary_i && iret_req_i;
  assign take_int = (state == ST_IDLE) && boundary_i && !iret_req_i && arb_any;
  assign nmi_clr  = take_int && grant[SRC_NMI];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      sp_w    <= '0;
      cs_s    <= '0;
      ip_s    <= '0;
      flags_s <= '0;
      new_cs  <= '0;
      new_ip  <= '0;
      vtype   <= '0;
      entry_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (take_ret) begin
            sp_w    <= sp_i;
            entry_q <= 1'b0;
            state   <= ST_POP_IP;
          end else if (take_int) begin
            sp_w    <= sp_i;
            cs_s    <= cs_i;
            ip_s    <= ip_i;
            flags_s <= flags_i;
            vtype   <= arb_type;
            entry_q <= 1'b1;
            state   <= grant[SRC_INTR] ? ST_ACK : ST_PUSH_F;
          end
        end
        ST_ACK: begin
          vtype <= ext_type_i;
          state <= ST_PUSH_F;
        end
        ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: if (mem_ack_i) begin
          sp_w  <= sp_w - DW'(2);
          state <= (state == ST_PUSH_F)  ? ST_PUSH_CS :
                   (state == ST_PUSH_CS) ? ST_PUSH_IP : ST_RD_IP;
        end
        ST_RD_IP: if (mem_ack_i) begin
          new_ip <= mem_rdata_i;
          state  <= ST_RD_CS;
        end
        ST_RD_CS: if (mem_ack_i) begin
          new_cs <= mem_rdata_i;
          state  <= ST_LOAD;
        end
        ST_POP_IP: if (mem_ack_i) begin
          new_ip <= mem_rdata_i;
          sp_w   <= sp_w + DW'(2);
          state  <= ST_POP_CS;
        end
        ST_POP_CS: if (mem_ack_i) begin
          new_cs <= mem_rdata_i;
          sp_w   <= sp_w + DW'(2);
          state  <= ST_POP_F;
        end
        ST_POP_F: if (mem_ack_i) begin
          flags_s <= mem_rdata_i;
          sp_w    <= sp_w + DW'(2);
          state   <= ST_LOAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    unique case (state)
      ST_PUSH_F:  begin mem_we_o = 1'b1; mem_wdata_o = flags_s; end
      ST_PUSH_CS: begin mem_we_o = 1'b1; mem_wdata_o = cs_s;    end
      ST_PUSH_IP: begin mem_we_o = 1'b1; mem_wdata_o = ip_s;    end
      default: ;
    endcase
  end

  assign mem_req_o = !(state inside {ST_IDLE, ST_ACK, ST_LOAD});
  assign inta_o    = (state == ST_ACK);
  assign busy_o    = (state != ST_IDLE);
  assign load_o    = (state == ST_LOAD);
  assign cs_o      = new_cs;
  assign ip_o      = new_ip;
  assign sp_o      = sp_w;
  assign flags_o   = entry_q ? (flags_s & CLR_MASK) : flags_s;

  // R6
  inta_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |=> !inta_o);
  // R6
  inta_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_o |-> busy_o && !mem_req_o);
  // R9
  load_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !busy_o && !load_o);
  // R9
  load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> busy_o);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  // R3
  entry_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o && entry_q |-> !flags_o[FLAG_IF] && !flags_o[FLAG_TF]);
endmodule

// File: tb/int_entry_seq_test.sv
module int_entry_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        boundary = 0, iret_req = 0, trap_req = 0, nmi = 0, intr = 0;
  logic [7:0]  trap_type = 0, ext_type = 0;
  logic [15:0] cs_in = 0, ip_in = 0, ss_in = 0, sp_in = 0, flags_in = 0;
  logic        inta, mem_req, mem_we, busy, load;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, cs_out, ip_out, sp_out, flags_out;
  logic [15:0] mem_rdata = 0;
  logic        mem_ack = 0;

  int total = 0, bad = 0, cyc = 0, inta_cnt = 0, act_cnt = 0, oob = 0;
  logic [15:0] mem [0:1023];

  always #2 clk = ~clk;

  int_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .iret_req_i(iret_req),
    .trap_req_i(trap_req), .trap_type_i(trap_type), .nmi_i(nmi), .intr_i(intr),
    .ext_type_i(ext_type), .inta_o(inta), .cs_i(cs_in), .ip_i(ip_in),
    .ss_i(ss_in), .sp_i(sp_in), .flags_i(flags_in), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .busy_o(busy), .load_o(load),
    .cs_o(cs_out), .ip_o(ip_out), .sp_o(sp_out), .flags_o(flags_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_addr[19:11] != 0 || mem_addr[0]) oob <= oob + 1;
      if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[10:1]];
    end else mem_ack <= 1'b0;
  end

  always @(negedge clk) begin
    if (inta) inta_cnt <= inta_cnt + 1;
    if (busy || mem_req) act_cnt <= act_cnt + 1;
  end

  function automatic logic [15:0] vip(int n);
    return 16'((n * 263) ^ 16'h5A00);
  endfunction
  function automatic logic [15:0] vcs(int n);
    return {8'(n), ~8'(n)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pulse boundary, return load latency (cycles after boundary edge), -1 on timeout
  task automatic step_boundary(output int lat);
    int c0;
    @(negedge clk); boundary = 1'b1; inta_cnt = 0;
    @(posedge clk); #1 c0 = cyc; boundary = 1'b0;
    lat = -1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (load) begin lat = cyc - c0; break; end
    end
  endtask

  task automatic check_entry(input string tag, input int n, input int exp_lat, input int exp_inta);
    int lat;
    logic [15:0] sp0, fl0, cs0, ip0;
    sp0 = sp_in; fl0 = flags_in; cs0 = cs_in; ip0 = ip_in;
    step_boundary(lat);
    chk(lat == exp_lat, {tag, " R9 latency"}, lat, exp_lat);
    chk(inta_cnt == exp_inta, {tag, " R6 inta pulses"}, inta_cnt, exp_inta);
    chk(ip_out == vip(n), {tag, " R1 ip"}, ip_out, vip(n));
    chk(cs_out == vcs(n), {tag, " R1 cs"}, cs_out, vcs(n));
    chk(flags_out == (fl0 & 16'hFCFF), {tag, " R3 flags"}, flags_out, fl0 & 16'hFCFF);
    chk(sp_out == sp0 - 16'd6, {tag, " R2 sp"}, sp_out, sp0 - 16'd6);
    chk(mem[10'((sp0 - 16'd2) >> 1)] == fl0, {tag, " R2 R3 pushed flags"},
        mem[10'((sp0 - 16'd2) >> 1)], fl0);
    chk(mem[10'((sp0 - 16'd4) >> 1)] == cs0, {tag, " R2 pushed cs"},
        mem[10'((sp0 - 16'd4) >> 1)], cs0);
    chk(mem[10'((sp0 - 16'd6) >> 1)] == ip0, {tag, " R2 pushed ip"},
        mem[10'((sp0 - 16'd6) >> 1)], ip0);
    @(negedge clk);
    chk(!busy && !load, {tag, " R9 release"}, {busy, load}, 0);
  endtask

  initial begin
    for (int n = 0; n < 256; n++) begin
      mem[2*n]   = vip(n);
      mem[2*n+1] = vcs(n);
    end
    for (int n = 512; n < 1024; n++) mem[n] = 16'hDEAD;
    ss_in = 16'h0000; sp_in = 16'h0800;
    repeat (3) @(negedge clk);
    chk(!busy && !load && !mem_req && !inta, "R9 reset state", {busy, load, mem_req, inta}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R4: maskable sweep, step also pending when TF set; maskable must win
    for (int t = 0; t < 256; t++) begin
      intr = 1; ext_type = 8'(t);
      cs_in = 16'h1000 + 16'(t); ip_in = 16'(t * 77);
      flags_in = 16'h0200 | (t[0] ? 16'h0100 : 16'h0) | 16'(t & 8'hC5);
      sp_in = 16'h0800 - 16'(2 * (t % 8));
      check_entry("maskable", t, 11, 1);
    end
    intr = 0; sp_in = 16'h0800;

    // R4: core trap over maskable (incl. type 0 divide overflow)
    for (int t = 0; t < 256; t++) begin
      trap_req = 1; trap_type = 8'(t); intr = 1; ext_type = 8'h77;
      cs_in = 16'hC000 ^ 16'(t); ip_in = 16'(t * 5 + 3);
      flags_in = 16'h0300 | 16'(t);
      check_entry("trap", t, 10, 0);
    end
    trap_req = 0;

    // R6: maskable ignored with enable clear
    flags_in = 16'h00D5; intr = 1; act_cnt = 0;
    @(negedge clk); boundary = 1; @(negedge clk); boundary = 0;
    repeat (20) @(negedge clk);
    chk(act_cnt == 0, "R6 masked request ignored", act_cnt, 0);

    // R5 R4: nmi pulse beats maskable, type 2
    @(negedge clk); nmi = 1; @(negedge clk); nmi = 0;
    repeat (3) @(negedge clk);
    flags_in = 16'h0200; intr = 1; ext_type = 8'h40; cs_in = 16'h2222; ip_in = 16'h3333;
    check_entry("R5 nmi pulse", 2, 10, 0);

    // R5 R4: nmi held high while trap taken, then served next boundary
    intr = 0; flags_in = 16'h0000;
    @(negedge clk); nmi = 1;
    trap_req = 1; trap_type = 8'h21;
    check_entry("R4 trap over nmi", 33, 10, 0);
    trap_req = 0;
    check_entry("R5 nmi pending kept", 2, 10, 0);
    // R5 R7: level still high, no retrigger; step taken instead
    flags_in = 16'h0100;
    check_entry("R7 step no nmi retrigger", 1, 10, 0);
    nmi = 0;

    // R7: step alone with enable clear
    flags_in = 16'h01AA; cs_in = 16'h4444; ip_in = 16'h5555;
    check_entry("R7 step", 1, 10, 0);

    // R8: return with interrupts pending
    begin
      int lat;
      mem[10'(16'h0700 >> 1)] = 16'hBEEF;
      mem[10'(16'h0702 >> 1)] = 16'hCAFE;
      mem[10'(16'h0704 >> 1)] = 16'h0312;
      sp_in = 16'h0700; flags_in = 16'h0300; intr = 1; trap_req = 1;
      iret_req = 1;
      step_boundary(lat);
      iret_req = 0; intr = 0; trap_req = 0;
      chk(lat == 6, "R8 R9 return latency", lat, 6);
      chk(inta_cnt == 0, "R8 no acknowledge", inta_cnt, 0);
      chk(ip_out == 16'hBEEF, "R8 ip", ip_out, 16'hBEEF);
      chk(cs_out == 16'hCAFE, "R8 cs", cs_out, 16'hCAFE);
      chk(flags_out == 16'h0312, "R8 flags restored", flags_out, 16'h0312);
      chk(sp_out == 16'h0706, "R8 sp", sp_out, 16'h0706);
    end

    chk(oob == 0, "R10 address range", oob, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule